// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table held in memory. A requester presents the virtual address together with a table base value. The walker fetches one word from the first-level table over a request/grant then read-valid memory handshake, and decodes that word. The word either ends the walk as a 1 MB section or points at a second-level table. In the second case the walker fetches and decodes a second-level word, which describes a 64 KB large page or a 4 KB small page.

Each walk ends with one response. A successful response carries:
- the physical address,
- the mapping size,
- the access-permission, execute-never, global and domain fields,
- the packed memory-type bits and the shareable flag.

A failed response carries a fault flag and the table level that faulted. Only one walk runs at a time, and `busy` tells the requester when a new walk can start.

Top module: `tw2_walker`

## Requirements
- R1: After reset, `busy`, `mem_req` and `rsp_valid` are all 0.
- R2: The first fetch address is {ttb[31:14], va[31:20], 2'b00}. While `mem_req` is high and `mem_gnt` is low, the request and its address stay unchanged.
- R3: A first-level word whose bits [1:0] are 00 or 11 ends the walk with `rsp_fault`=1 and `rsp_level`=1, and no second fetch is made. On every fault, `rsp_pa`, `rsp_size`, `rsp_ap`, `rsp_xn`, `rsp_global`, `rsp_domain`, `rsp_texcb` and `rsp_shared` are 0.
- R4: A first-level word with bits [1:0]=10 and bit 18 clear is a section. It gives `rsp_pa`={desc[31:20], va[19:0]}, `rsp_size`=0 and `rsp_level`=1.
- R5: A first-level word with bits [1:0]=10 and bit 18 set ends the walk as a level-1 fault.
- R6: A section's fields are decoded as follows:
  - `rsp_ap`={d[15], d[11:10]}
  - `rsp_xn`=d[4]
  - `rsp_global`=!d[17]
  - `rsp_domain`=d[8:5]
  - `rsp_texcb`={d[14:12], d[3], d[2]}
  - `rsp_shared`=d[16]
- R7: A first-level word with bits [1:0]=01 causes a second fetch at {desc[31:10], va[19:12], 2'b00}.
- R8: A second-level word with bits [1:0]=00 ends the walk with `rsp_fault`=1 and `rsp_level`=2.
- R9: A second-level word with bit 1 clear and bit 0 set is a large page. It gives `rsp_pa`={d[31:16], va[15:0]}, `rsp_xn`=d[15], `rsp_texcb`={d[14:12], d[3], d[2]} and `rsp_size`=1.
- R10: A second-level word with bit 1 set is a small page. It gives `rsp_pa`={d[31:12], va[11:0]}, `rsp_xn`=d[0], `rsp_texcb`={d[8:6], d[3], d[2]} and `rsp_size`=2.
- R11: Both second-level page sizes give the following, with `rsp_level`=2:
  - `rsp_ap`={d[9], d[5:4]}
  - `rsp_global`=!d[11]
  - `rsp_shared`=d[10]
  - `rsp_domain` equal to bits [8:5] of the first-level word
- R12: A request is taken only while `busy` is 0. `busy` stays 1 from the cycle after acceptance through the single `rsp_valid` cycle. `req_valid` pulses while busy start nothing and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_va | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | First-level table base |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_gnt | input | 1 | Request accepted by memory |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation fault |
| rsp_level | output | 2 | Level of the word that ended the walk (1 or 2) |
| rsp_size | output | 2 | 0 section, 1 large page, 2 small page |
| rsp_pa | output | 32 | Physical address |
| rsp_ap | output | 3 | Access permission bits |
| rsp_xn | output | 1 | Execute-never |
| rsp_global | output | 1 | Mapping is global |
| rsp_domain | output | 4 | Domain number |
| rsp_texcb | output | 5 | {tex[2:0], C, B} |
| rsp_shared | output | 1 | Shareable |

## Verification
The hardest case to reach is a second-level walk whose memory grant and read data arrive late, while the requester keeps pulsing `req_valid`. In that case the stored first-level domain and table base must survive several idle cycles, and the stray requests must be ignored. The bench's memory model makes the grant delay and read latency adjustable for each walk. It checks every fetch address against a separately computed expectation, and it injects a request pulse in the middle of a walk. It then confirms that `busy` drops and that no extra response appears.

// File: rtl/tw2_pkg.sv
package tw2_pkg;

  localparam int AW = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_RESP
  } tw2_state_e;

  typedef struct packed {
    logic            fault;
    logic [1:0]      level;
    logic [1:0]      size;
    logic [AW-1:0]   pa;
    logic [2:0]      ap;
    logic            xn;
    logic            glob;
    logic [3:0]      domain;
    logic [4:0]      texcb;
    logic            shared;
  } tw2_result_t;

  function automatic logic [AW-1:0] l1_fetch_addr(input logic [AW-1:0] ttb,
                                                   input logic [AW-1:0] va);
    return {ttb[31:14], va[31:20], 2'b00};
  endfunction

  function automatic logic [AW-1:0] l2_fetch_addr(input logic [21:0] base,
                                                   input logic [AW-1:0] va);
    return {base, va[19:12], 2'b00};
  endfunction

  function automatic tw2_result_t fault_res(input logic [1:0] lvl);
    tw2_result_t r;
    r = '0;
    r.fault = 1'b1;
    r.level = lvl;
    return r;
  endfunction

  function automatic tw2_result_t section_res(input logic [31:0] d,
                                              input logic [AW-1:0] va);
    tw2_result_t r;
    r.fault  = 1'b0;
    r.level  = 2'd1;
    r.size   = 2'd0;
    r.pa     = {d[31:20], va[19:0]};
    r.ap     = {d[15], d[11:10]};
    r.xn     = d[4];
    r.glob   = ~d[17];
    r.domain = d[8:5];
    r.texcb  = {d[14:12], d[3], d[2]};
    r.shared = d[16];
    return r;
  endfunction

  function automatic tw2_result_t page_res(input logic [31:0] d,
                                           input logic [AW-1:0] va,
                                           input logic [3:0] dom);
    tw2_result_t r;
    r.fault  = 1'b0;
    r.level  = 2'd2;
    r.ap     = {d[9], d[5:4]};
    r.glob   = ~d[11];
    r.shared = d[10];
    r.domain = dom;
    if (!d[1]) begin
      r.size  = 2'd1;
      r.pa    = {d[31:16], va[15:0]};
      r.xn    = d[15];
      r.texcb = {d[14:12], d[3], d[2]};
    end else begin
      r.size  = 2'd2;
      r.pa    = {d[31:12], va[11:0]};
      r.xn    = d[0];
      r.texcb = {d[8:6], d[3], d[2]};
    end
    return r;
  endfunction

endpackage

// File: rtl/tw2_addr_gen.sv
module tw2_addr_gen
  import tw2_pkg::*;
(
  input  logic          second,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] ttb,
  input  logic [21:0]   l2_base,
  output logic [AW-1:0] addr
);
  always_comb begin
    if (second) addr = l2_fetch_addr(l2_base, va);
    else        addr = l1_fetch_addr(ttb, va);
  end
endmodule

// File: rtl/tw2_desc_decode.sv
module tw2_desc_decode
  import tw2_pkg::*;
(
  input  logic          second,
  input  logic [31:0]   desc,
  input  logic [AW-1:0] va,
  input  logic [3:0]    dom_in,
  output logic          is_table,
  output tw2_result_t   res
);
  always_comb begin
    is_table = 1'b0;
    res      = fault_res(2'd1);
    if (second) begin
      if (desc[1:0] == 2'b00) res = fault_res(2'd2);
      else                    res = page_res(desc, va, dom_in);
    end else begin
      unique case (desc[1:0])
        2'b01:   is_table = 1'b1;
        2'b10:   res = desc[18] ? fault_res(2'd1) : section_res(desc, va);
        default: res = fault_res(2'd1);
      endcase
    end
  end
endmodule

// File: rtl/tw2_walker.sv
module tw2_walker
  import tw2_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic [31:0] req_ttb,
  output logic        busy,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [1:0]  rsp_level,
  output logic [1:0]  rsp_size,
  output logic [31:0] rsp_pa,
  output logic [2:0]  rsp_ap,
  output logic        rsp_xn,
  output logic        rsp_global,
  output logic [3:0]  rsp_domain,
  output logic [4:0]  rsp_texcb,
  output logic        rsp_shared
);
  tw2_state_e   state;
  logic [AW-1:0] va_q, ttb_q;
  logic [21:0]  l2_base_q;
  logic [3:0]   dom_q;
  tw2_result_t  res_q, dec_res;
  logic         dec_table;
  logic         in_l2;

  // named events for the checker
  logic walk_accept, l1_beat, l2_beat;
  assign walk_accept = (state == S_IDLE) && req_valid;
  assign l1_beat     = (state == S_L1_WAIT) && mem_rvalid;
  assign l2_beat     = (state == S_L2_WAIT) && mem_rvalid;
  assign in_l2       = (state == S_L2_REQ) || (state == S_L2_WAIT);

  tw2_addr_gen u_addr (
    .second (in_l2),
    .va     (va_q),
    .ttb    (ttb_q),
    .l2_base(l2_base_q),
    .addr   (mem_addr)
  );

  tw2_desc_decode u_dec (
    .second  (in_l2),
    .desc    (mem_rdata),
    .va      (va_q),
    .dom_in  (dom_q),
    .is_table(dec_table),
    .res     (dec_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      va_q      <= '0;
      ttb_q     <= '0;
      l2_base_q <= '0;
      dom_q     <= '0;
      res_q     <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (walk_accept) begin
          va_q  <= req_va;
          ttb_q <= req_ttb;
          state <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_gnt) state <= S_L1_WAIT;
        S_L1_WAIT: if (l1_beat) begin
          if (dec_table) begin
            l2_base_q <= mem_rdata[31:10];
            dom_q     <= mem_rdata[8:5];
            state     <= S_L2_REQ;
          end else begin
            res_q <= dec_res;
            state <= S_RESP;
          end
        end
        S_L2_REQ: if (mem_gnt) state <= S_L2_WAIT;
        S_L2_WAIT: if (l2_beat) begin
          res_q <= dec_res;
          state <= S_RESP;
        end
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign mem_req    = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign rsp_valid  = (state == S_RESP);
  assign rsp_fault  = res_q.fault;
  assign rsp_level  = res_q.level;
  assign rsp_size   = res_q.size;
  assign rsp_pa     = res_q.pa;
  assign rsp_ap     = res_q.ap;
  assign rsp_xn     = res_q.xn;
  assign rsp_global = res_q.glob;
  assign rsp_domain = res_q.domain;
  assign rsp_texcb  = res_q.texcb;
  assign rsp_shared = res_q.shared;
endmodule

// File: rtl/tw2_walker_chk.sv
module tw2_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [1:0]  rsp_level,
  input logic [1:0]  rsp_size,
  input logic [31:0] rsp_pa,
  input logic        walk_accept,
  input logic        l1_beat,
  input logic        l2_beat
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R12
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> busy && mem_req);

  // R12
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && !busy);

  // R3
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_level == 2'd1 || rsp_level == 2'd2)
                               && rsp_pa == '0 && rsp_size == 2'd0);

  // R4
  section_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && rsp_size == 2'd0 |-> rsp_level == 2'd1);

  // R11
  page_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && rsp_size != 2'd0 |-> rsp_level == 2'd2);

  // R12
  beat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_beat || l2_beat) |-> busy && !mem_req);
endmodule

bind tw2_walker tw2_walker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_level  (rsp_level),
  .rsp_size   (rsp_size),
  .rsp_pa     (rsp_pa),
  .walk_accept(walk_accept),
  .l1_beat    (l1_beat),
  .l2_beat    (l2_beat)
);

// File: tb/tb_tw2_walker.sv
`timescale 1ns/1ps
module tb_tw2_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_va = 0, req_ttb = 0;
  logic        busy, mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic        rsp_valid, rsp_fault, rsp_xn, rsp_global, rsp_shared;
  logic [1:0]  rsp_level, rsp_size;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_ap;
  logic [3:0]  rsp_domain;
  logic [4:0]  rsp_texcb;

  always #2.5 clk = ~clk;

  tw2_walker dut (.*);

  typedef struct {
    logic [51:0] v;
    int          nf;
    logic [31:0] a1, a2;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int   errors = 0, checks = 0;
  int   gnt_dly = 0, rd_lat = 0;
  int   fetch_idx = 0;
  logic [31:0] m_a1, m_a2, m_d1, m_d2;
  int   m_nf;
  bit   finished = 0;

  function automatic exp_t model(input logic [31:0] va, ttb, d1, d2, input string tag);
    exp_t e;
    logic f; logic [1:0] lv, sz; logic [31:0] pa; logic [2:0] ap;
    logic xn, gl, sh; logic [3:0] dm; logic [4:0] tc;
    f = 0; lv = 1; sz = 0; pa = 0; ap = 0; xn = 0; gl = 0; sh = 0; dm = 0; tc = 0;
    e.a1 = (ttb & 32'hFFFF_C000) | ((va >> 20) << 2);
    e.a2 = 0; e.nf = 1; e.tag = tag;
    if ((d1 & 3) == 1) begin
      e.nf = 2; lv = 2;
      e.a2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
      if ((d2 & 3) == 0) f = 1;
      else begin
        dm = 4'((d1 >> 5) & 15);
        ap = 3'((d2[9] << 2) | ((d2 >> 4) & 3));
        gl = !d2[11]; sh = d2[10];
        if (d2[1] == 0) begin
          sz = 1; pa = (d2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF); xn = d2[15];
          tc = 5'((((d2 >> 12) & 7) << 2) | ((d2 >> 2) & 3));
        end else begin
          sz = 2; pa = (d2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF); xn = d2[0];
          tc = 5'((((d2 >> 6) & 7) << 2) | ((d2 >> 2) & 3));
        end
      end
    end else if ((d1 & 3) == 2 && !d1[18]) begin
      pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
      ap = 3'((d1[15] << 2) | ((d1 >> 10) & 3));
      xn = d1[4]; gl = !d1[17]; dm = 4'((d1 >> 5) & 15);
      tc = 5'((((d1 >> 12) & 7) << 2) | ((d1 >> 2) & 3)); sh = d1[16];
    end else f = 1;
    e.v = {f, lv, sz, pa, ap, xn, gl, dm, tc, sh};
    return e;
  endfunction

  // memory responder
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      repeat (gnt_dly) @(negedge clk);
      checks++;
      if (fetch_idx == 0 && mem_addr !== m_a1) begin
        errors++; $display("FAIL R2 fetch addr act=%h exp=%h", mem_addr, m_a1);
      end else if (fetch_idx == 1 && (m_nf < 2 || mem_addr !== m_a2)) begin
        errors++; $display("FAIL R7 second fetch act=%h exp=%h nf=%0d (R3/R5 if nf=1)", mem_addr, m_a2, m_nf);
      end else if (fetch_idx > 1) begin
        errors++; $display("FAIL R12 extra fetch act=%h exp=none", mem_addr);
      end
      mem_gnt = 1;
      @(negedge clk);
      mem_gnt = 0;
      repeat (rd_lat) @(negedge clk);
      mem_rvalid = 1;
      mem_rdata = (fetch_idx == 0) ? m_d1 : m_d2;
      fetch_idx++;
      @(negedge clk);
      mem_rvalid = 0;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      logic [51:0] act;
      act = {rsp_fault, rsp_level, rsp_size, rsp_pa, rsp_ap, rsp_xn, rsp_global,
             rsp_domain, rsp_texcb, rsp_shared};
      checks++;
      if (expq.size() == 0) begin
        errors++; $display("FAIL R12 unexpected response act=%h exp=none", act);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (act !== e.v) begin
          errors++; $display("FAIL %s act=%h exp=%h", e.tag, act, e.v);
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, ttb, d1, d2, input int gd, rl,
                      input bit poke, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    e = model(va, ttb, d1, d2, tag);
    m_a1 = e.a1; m_a2 = e.a2; m_d1 = d1; m_d2 = d2; m_nf = e.nf;
    fetch_idx = 0; gnt_dly = gd; rd_lat = rl;
    expq.push_back(e);
    req_valid = 1; req_va = va; req_ttb = ttb;
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (busy !== 1'b1) begin errors++; $display("FAIL R12 busy after accept act=%b exp=1", busy); end
    if (poke) begin
      req_valid = 1; req_va = ~va; req_ttb = ~ttb;
      @(negedge clk);
      req_valid = 0;
    end
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (fetch_idx != e.nf || busy !== 1'b0) begin
      errors++; $display("FAIL %s fetches/busy act=%0d/%b exp=%0d/0", tag, fetch_idx, busy, e.nf);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (busy !== 0 || mem_req !== 0 || rsp_valid !== 0) begin
      errors++; $display("FAIL R1 reset act=%b%b%b exp=000", busy, mem_req, rsp_valid);
    end
    // R4 R6 sections, several patterns
    walk(32'h1234_5678, 32'h8000_4000, 32'hABC1_F5FE & ~32'h4_0000 | 32'h2, 0, 0, 0, 0, "R4/R6");
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0002_0012, 0, 2, 1, 0, "R4/R6");
    walk(32'h0000_0000, 32'h0000_0000, 32'hFFF1_7DBE & ~32'h4_0000, 0, 1, 3, 0, "R4/R6");
    // R5 supersection
    walk(32'h4567_89AB, 32'h1234_8000, 32'h0004_0002, 0, 0, 0, 0, "R5");
    // R3 level-1 faults
    walk(32'h9000_0000, 32'h0001_0000, 32'hFFFF_FFFC, 32'h2, 1, 0, 0, "R3");
    walk(32'h9000_0000, 32'h0001_0000, 32'hFFFF_FFFF & ~32'h0, 32'h2, 0, 2, 0, "R3");
    // R7 R9 R11 large page
    walk(32'hCAFE_BABE, 32'h0040_0000, 32'h1234_5561, 32'h9876_F6B5, 2, 2, 0, "R9/R11");
    walk(32'h0012_3456, 32'h0040_0000, 32'h0000_0C01, 32'h0000_0001, 0, 0, 0, "R9/R11");
    // R7 R10 R11 small page
    walk(32'hDEAD_BEEF, 32'h7777_C000, 32'hFEDC_B9E1, 32'h5555_FFFF, 1, 1, 0, "R10/R11");
    walk(32'h0FF0_1234, 32'h0000_4000, 32'h0000_0021, 32'hAAAA_A012, 3, 0, 0, "R10/R11");
    // R8 level-2 fault
    walk(32'h3333_3333, 32'h0000_8000, 32'h5A5A_5BE1, 32'hFFFF_FFFC, 1, 2, 0, "R8");
    // R12 stray request while busy, with slow memory
    walk(32'hABCD_EF01, 32'h2222_0000, 32'h0101_0181, 32'h1357_9BDE, 4, 4, 1, "R12/R10");
    walk(32'h5000_0000, 32'h2222_0000, 32'h5000_0C02, 0, 3, 3, 1, "R12/R4");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule